// File: doc/BRIEF.md
# Instruction Word Decoder

This block takes one 16-bit instruction word and decodes it into the information an execution pipeline needs before it touches memory. It puts the word into one of three layouts: a one-operand operation, a relative branch, or a two-operand operation. It extracts the operation code, the byte/word flag and the register numbers. It then works out how each operand is reached.

Some register and mode pairs do not address a register. They stand for a constant, an absolute address, a PC-relative address or an inline immediate. The decoder resolves these pairs, and they change how many extension words follow the instruction. The block reports the extension-word count, the branch displacement in bytes and an estimate of the clock cycles needed.

Decoding is combinational. The result is captured in output registers, so it appears one clock after a word is offered with `in_valid`. Fetching the extension words and carrying out the operation are left to the surrounding pipeline.

Top module: `instr_decoder`

## Requirements
- R1: `fmt` gives the layout of the word: 0 = one-operand when bits 15:10 are 000100; 1 = branch when bits 15:13 are 001; 2 = two-operand when bits 15:14 are not 00; 3 = unassigned, and `illegal` is set, for any other word.
- R2: `opcode` is bits 15:12 for a two-operand word and {0, bits 9:7} for a one-operand word. `byte_op` is bit 6, where 1 means byte and 0 means word. For a two-operand word, `src_reg` is bits 11:8 and `dst_reg` is bits 3:0. For a one-operand word, `src_reg` is bits 3:0.
- R3: `src_kind` and `dst_kind` use these codes: 0 register, 1 indexed, 2 indirect, 3 indirect with post-increment, 4 PC-relative, 5 absolute, 6 immediate, 7 constant, 8 none. For a register other than 0, 2 or 3, source mode bits 5:4 = 00/01/10/11 give codes 0/1/2/3. The destination flag (bit 7) gives 0 or 1. A one-operand word has `dst_kind` 8.
- R4: With register 0, source mode 01 gives code 4 and source mode 11 gives code 6. A destination flag of 1 with register 0 gives code 4.
- R5: With register 2, source mode 01 gives code 5. Source mode 10 gives code 7 with `src_const` 4, and source mode 11 gives code 7 with `src_const` 8. A destination flag of 1 with register 2 gives code 5.
- R6: With register 3 as the source, modes 00, 01, 10 and 11 give code 7 with `src_const` 0x0000, 0x0001, 0x0002 and 0xFFFF, and none of them adds an extension word. `src_const` is 0 whenever `src_kind` is not 7.
- R7: `ext_words` counts one word for each operand of kind 1, 4, 5 or 6. The count is 0, 1 or 2.
- R8: `cycles` is counted as follows:
  - Base: 1 for the instruction word, plus `ext_words`, plus 1 when the source operand is read from memory (kinds 1 to 5).
  - Two-operand memory destination (kinds 1, 4, 5): add 1 for a move (opcode 0100), 1 for a compare or bit test (1001, 1011), and 2 for any other opcode.
  - One-operand words: opcodes 000–011 add 1 when the operand is in memory; push and call (100, 101) always add 1.
  - Fixed values: 2 for any branch and 3 for a return-from-interrupt.
- R9: For a branch, `opcode` is {0, bits 12:10}. `jump_disp` is the sign-extended 10-bit field in bits 9:0, multiplied by two.
- R10: A one-operand word with opcode 110 and bits 5:0 zero sets `is_reti`, with both kinds 8. The following set `illegal`: opcode 110 with any of bits 5:0 set, opcode 111, or opcode 001, 011 or 101 with the byte flag set. While `illegal` is set, both kinds are 8 and `ext_words` and `cycles` are 0.
- R11: The decoded outputs update on the clock edge that samples `in_valid` = 1, and `out_valid` follows `in_valid` one clock later. While `in_valid` is 0, every decoded output holds its value. Synchronous reset clears `out_valid`, sets both kinds to 8, sets `fmt` to 3 and sets all other outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result valid |
| fmt | output | 2 | Layout code |
| opcode | output | 4 | Operation or branch condition |
| byte_op | output | 1 | Byte-size operation |
| src_reg | output | 4 | Source or single operand register |
| dst_reg | output | 4 | Destination register |
| src_kind | output | 4 | Source access kind |
| dst_kind | output | 4 | Destination access kind |
| src_const | output | 16 | Generated constant |
| ext_words | output | 2 | Extension words following |
| cycles | output | 3 | Estimated cycle count |
| jump_disp | output | 16 | Branch byte displacement |
| is_reti | output | 1 | Return from interrupt |
| illegal | output | 1 | Unassigned encoding |

## Verification
Two functions can land in the same decode: the constant generator acting on the source, and extension-word counting for an indexed, PC-relative or absolute destination. The bench provokes this with words that pair a register-3 or register-2 constant source with a memory destination. For example, an AND of the all-ones constant into an indexed destination must report `src_const` 0xFFFF, exactly one extension word and four cycles. A decoder that charged the constant an index word, or that let the constant path mask the destination count, is caught by the counts. Table vectors also pair PC-relative and indexed operands, so that both counters run at once.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int INSN_W = 16;
  localparam int REG_W  = 4;
  localparam int OPC_W  = 4;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'd0,
    FMT_JUMP   = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_NONE   = 2'd3
  } fmt_e;

  typedef enum logic [3:0] {
    K_REG   = 4'd0,
    K_IDX   = 4'd1,
    K_IND   = 4'd2,
    K_AINC  = 4'd3,
    K_SYM   = 4'd4,
    K_ABS   = 4'd5,
    K_IMM   = 4'd6,
    K_CONST = 4'd7,
    K_NONE  = 4'd8
  } kind_e;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic [INSN_W-1:0] instr,
  output fmt_e              fmt,
  output logic [OPC_W-1:0]  opcode,
  output logic              byte_op,
  output logic [REG_W-1:0]  src_reg,
  output logic [REG_W-1:0]  dst_reg,
  output logic [1:0]        src_mode,
  output logic [1:0]        dst_mode,
  output logic              src_used,
  output logic              dst_used,
  output logic [DISP_W-1:0] disp,
  output logic              is_reti,
  output logic              illegal
);
  localparam int OFS_W = 10;

  always_comb begin
    fmt      = FMT_NONE;
    opcode   = '0;
    byte_op  = 1'b0;
    src_reg  = '0;
    dst_reg  = '0;
    src_mode = 2'b00;
    dst_mode = 2'b00;
    src_used = 1'b0;
    dst_used = 1'b0;
    disp     = '0;
    is_reti  = 1'b0;
    illegal  = 1'b0;
    if (instr[15:10] == 6'b000100) begin
      fmt      = FMT_SINGLE;
      opcode   = {1'b0, instr[9:7]};
      byte_op  = instr[6];
      src_reg  = instr[3:0];
      src_mode = instr[5:4];
      src_used = 1'b1;
      case (instr[9:7])
        3'b001, 3'b011, 3'b101: illegal = instr[6];
        3'b110: begin
          if (instr[5:0] == 6'd0) begin
            is_reti  = 1'b1;
            src_used = 1'b0;
          end else begin
            illegal = 1'b1;
          end
        end
        3'b111:  illegal = 1'b1;
        default: illegal = 1'b0;
      endcase
    end else if (instr[15:13] == 3'b001) begin
      fmt    = FMT_JUMP;
      opcode = {1'b0, instr[12:10]};
      disp   = {{(DISP_W-OFS_W-1){instr[OFS_W-1]}}, instr[OFS_W-1:0], 1'b0};
    end else if (instr[15:14] != 2'b00) begin
      fmt      = FMT_DOUBLE;
      opcode   = instr[15:12];
      src_reg  = instr[11:8];
      dst_mode = {1'b0, instr[7]};
      byte_op  = instr[6];
      src_mode = instr[5:4];
      dst_reg  = instr[3:0];
      src_used = 1'b1;
      dst_used = 1'b1;
    end else begin
      illegal = 1'b1;
    end
    if (illegal) begin
      src_used = 1'b0;
      dst_used = 1'b0;
    end
  end
endmodule

// File: rtl/idec_operand.sv
module idec_operand
  import idec_pkg::*;
#(
  parameter bit IS_DST = 1'b0,
  parameter int DATA_W = 16
) (
  input  logic              used,
  input  logic [REG_W-1:0]  rnum,
  input  logic [1:0]        mode,
  output kind_e             kind,
  output logic [DATA_W-1:0] cval,
  output logic              needs_ext,
  output logic              in_mem
);
  localparam logic [REG_W-1:0] RN_PC = REG_W'(0);
  localparam logic [REG_W-1:0] RN_SR = REG_W'(2);
  localparam logic [REG_W-1:0] RN_CG = REG_W'(3);

  logic cg_ok;

  generate
    if (IS_DST) begin : g_dst
      assign cg_ok = 1'b0;
    end else begin : g_src
      assign cg_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    kind = K_NONE;
    cval = '0;
    if (used) begin
      case (mode)
        2'b00: begin
          if (cg_ok && rnum == RN_CG) kind = K_CONST;
          else                        kind = K_REG;
        end
        2'b01: begin
          if (rnum == RN_PC)               kind = K_SYM;
          else if (rnum == RN_SR)          kind = K_ABS;
          else if (cg_ok && rnum == RN_CG) begin
            kind = K_CONST;
            cval = DATA_W'(1);
          end else                         kind = K_IDX;
        end
        2'b10: begin
          if (cg_ok && rnum == RN_SR) begin
            kind = K_CONST;
            cval = DATA_W'(4);
          end else if (cg_ok && rnum == RN_CG) begin
            kind = K_CONST;
            cval = DATA_W'(2);
          end else kind = K_IND;
        end
        default: begin
          if (cg_ok && rnum == RN_PC) kind = K_IMM;
          else if (cg_ok && rnum == RN_SR) begin
            kind = K_CONST;
            cval = DATA_W'(8);
          end else if (cg_ok && rnum == RN_CG) begin
            kind = K_CONST;
            cval = '1;
          end else kind = K_AINC;
        end
      endcase
    end
  end

  assign needs_ext = (kind == K_IDX) || (kind == K_SYM) ||
                     (kind == K_ABS) || (kind == K_IMM);
  assign in_mem    = (kind == K_IDX) || (kind == K_IND) || (kind == K_AINC) ||
                     (kind == K_SYM) || (kind == K_ABS);
endmodule

// File: rtl/idec_cost.sv
module idec_cost
  import idec_pkg::*;
#(
  parameter int CYC_W = 3
) (
  input  fmt_e              fmt,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              illegal,
  input  logic              is_reti,
  input  logic              s_ext,
  input  logic              s_mem,
  input  logic              d_ext,
  input  logic              d_mem,
  output logic [1:0]        ext_words,
  output logic [CYC_W-1:0]  cycles
);
  localparam logic [OPC_W-1:0] OP_MOVE = 4'b0100;
  localparam logic [OPC_W-1:0] OP_CMP  = 4'b1001;
  localparam logic [OPC_W-1:0] OP_TEST = 4'b1011;

  logic [CYC_W-1:0] base;
  logic [CYC_W-1:0] dst_cost;
  logic [CYC_W-1:0] one_cost;

  always_comb begin
    ext_words = {1'b0, s_ext} + {1'b0, d_ext};
    base      = CYC_W'(1) + CYC_W'(ext_words) + CYC_W'(s_mem);
    if (!d_mem)
      dst_cost = '0;
    else if (opcode == OP_MOVE || opcode == OP_CMP || opcode == OP_TEST)
      dst_cost = CYC_W'(1);
    else
      dst_cost = CYC_W'(2);
    one_cost = opcode[2] ? CYC_W'(1) : CYC_W'(s_mem);
    if (illegal) begin
      ext_words = 2'd0;
      cycles    = '0;
    end else begin
      case (fmt)
        FMT_JUMP:   cycles = CYC_W'(2);
        FMT_SINGLE: cycles = is_reti ? CYC_W'(3) : base + one_cost;
        FMT_DOUBLE: cycles = base + dst_cost;
        default:    cycles = '0;
      endcase
    end
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CYC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [15:0]       instr,
  output logic              out_valid,
  output logic [1:0]        fmt,
  output logic [3:0]        opcode,
  output logic              byte_op,
  output logic [3:0]        src_reg,
  output logic [3:0]        dst_reg,
  output logic [3:0]        src_kind,
  output logic [3:0]        dst_kind,
  output logic [DATA_W-1:0] src_const,
  output logic [1:0]        ext_words,
  output logic [CYC_W-1:0]  cycles,
  output logic [DATA_W-1:0] jump_disp,
  output logic              is_reti,
  output logic              illegal
);
  fmt_e              c_fmt;
  logic [OPC_W-1:0]  c_opc;
  logic              c_byte;
  logic [REG_W-1:0]  c_sreg, c_dreg;
  logic [1:0]        c_smode, c_dmode;
  logic              c_sused, c_dused;
  logic [DATA_W-1:0] c_disp;
  logic              c_reti, c_ill;
  kind_e             c_skind, c_dkind;
  logic [DATA_W-1:0] c_sconst, c_dconst;
  logic              c_sext, c_smem, c_dext, c_dmem;
  logic [1:0]        c_ext;
  logic [CYC_W-1:0]  c_cyc;

  idec_fields #(.DISP_W(DATA_W)) u_fields (
    .instr(instr), .fmt(c_fmt), .opcode(c_opc), .byte_op(c_byte),
    .src_reg(c_sreg), .dst_reg(c_dreg), .src_mode(c_smode), .dst_mode(c_dmode),
    .src_used(c_sused), .dst_used(c_dused), .disp(c_disp),
    .is_reti(c_reti), .illegal(c_ill)
  );

  idec_operand #(.IS_DST(1'b0), .DATA_W(DATA_W)) u_src (
    .used(c_sused), .rnum(c_sreg), .mode(c_smode), .kind(c_skind),
    .cval(c_sconst), .needs_ext(c_sext), .in_mem(c_smem)
  );

  idec_operand #(.IS_DST(1'b1), .DATA_W(DATA_W)) u_dst (
    .used(c_dused), .rnum(c_dreg), .mode(c_dmode), .kind(c_dkind),
    .cval(c_dconst), .needs_ext(c_dext), .in_mem(c_dmem)
  );

  idec_cost #(.CYC_W(CYC_W)) u_cost (
    .fmt(c_fmt), .opcode(c_opc), .illegal(c_ill), .is_reti(c_reti),
    .s_ext(c_sext), .s_mem(c_smem), .d_ext(c_dext), .d_mem(c_dmem),
    .ext_words(c_ext), .cycles(c_cyc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      fmt       <= FMT_NONE;
      opcode    <= '0;
      byte_op   <= 1'b0;
      src_reg   <= '0;
      dst_reg   <= '0;
      src_kind  <= K_NONE;
      dst_kind  <= K_NONE;
      src_const <= '0;
      ext_words <= '0;
      cycles    <= '0;
      jump_disp <= '0;
      is_reti   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fmt       <= c_fmt;
        opcode    <= c_opc;
        byte_op   <= c_byte;
        src_reg   <= c_sreg;
        dst_reg   <= c_dreg;
        src_kind  <= c_skind;
        dst_kind  <= c_dkind;
        src_const <= c_sconst | c_dconst;
        ext_words <= c_ext;
        cycles    <= c_cyc;
        jump_disp <= c_disp;
        is_reti   <= c_reti;
        illegal   <= c_ill;
      end
    end
  end
endmodule

// File: rtl/idec_checker.sv
module idec_checker #(
  parameter int DATA_W = 16,
  parameter int CYC_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [15:0]       instr,
  input logic              out_valid,
  input logic [1:0]        fmt,
  input logic [3:0]        src_kind,
  input logic [3:0]        dst_kind,
  input logic [DATA_W-1:0] src_const,
  input logic [1:0]        ext_words,
  input logic [CYC_W-1:0]  cycles,
  input logic              illegal
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(cycles) && $stable(src_kind) && $stable(fmt)));

  a_r1_branch_layout: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:13] == 3'b001) |=> (fmt == 2'd1 && cycles == CYC_W'(2)));

  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (src_kind == 4'd8 && dst_kind == 4'd8 && ext_words == 2'd0 && cycles == '0));

  a_r6_const_zero_else: assert property (@(posedge clk) disable iff (rst)
    (src_kind != 4'd7) |-> (src_const == '0));

  a_r6_const_no_word: assert property (@(posedge clk) disable iff (rst)
    (out_valid && src_kind == 4'd7 && (dst_kind == 4'd0 || dst_kind == 4'd8)) |-> (ext_words == 2'd0));

  a_r8_cycle_floor: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |-> (cycles > CYC_W'(ext_words)));

  a_r3_dst_never_const: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (dst_kind != 4'd7 && dst_kind != 4'd6));
endmodule

bind instr_decoder idec_checker #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_idec_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
  .out_valid(out_valid), .fmt(fmt), .src_kind(src_kind), .dst_kind(dst_kind),
  .src_const(src_const), .ext_words(ext_words), .cycles(cycles), .illegal(illegal)
);

// File: tb/instr_decoder_bench.sv
`timescale 1ns/1ps
module instr_decoder_bench;
  localparam int NV = 27;
  // {instr, fmt, src_kind, dst_kind, src_const, ext_words, cycles, illegal}
  localparam logic [47:0] VEC [0:NV-1] = '{
    {16'h4405, 2'd2, 4'd0, 4'd0, 16'h0000, 2'd0, 3'd1, 1'b0},
    {16'h5495, 2'd2, 4'd1, 4'd1, 16'h0000, 2'd2, 3'd6, 1'b0},
    {16'h4036, 2'd2, 4'd6, 4'd0, 16'h0000, 2'd1, 3'd2, 1'b0},
    {16'h4217, 2'd2, 4'd5, 4'd0, 16'h0000, 2'd1, 3'd3, 1'b0},
    {16'h5228, 2'd2, 4'd7, 4'd0, 16'h0004, 2'd0, 3'd1, 1'b0},
    {16'h5238, 2'd2, 4'd7, 4'd0, 16'h0008, 2'd0, 3'd1, 1'b0},
    {16'h5309, 2'd2, 4'd7, 4'd0, 16'h0000, 2'd0, 3'd1, 1'b0},
    {16'h5319, 2'd2, 4'd7, 4'd0, 16'h0001, 2'd0, 3'd1, 1'b0},
    {16'h5329, 2'd2, 4'd7, 4'd0, 16'h0002, 2'd0, 3'd1, 1'b0},
    {16'h5339, 2'd2, 4'd7, 4'd0, 16'hFFFF, 2'd0, 3'd1, 1'b0},
    {16'h94A0, 2'd2, 4'd2, 4'd4, 16'h0000, 2'd1, 3'd4, 1'b0},
    {16'h45B2, 2'd2, 4'd3, 4'd5, 16'h0000, 2'd1, 3'd4, 1'b0},
    {16'h5095, 2'd2, 4'd4, 4'd1, 16'h0000, 2'd2, 3'd6, 1'b0},
    {16'hF3B4, 2'd2, 4'd7, 4'd1, 16'hFFFF, 2'd1, 3'd4, 1'b0},
    {16'h1005, 2'd0, 4'd0, 4'd8, 16'h0000, 2'd0, 3'd1, 1'b0},
    {16'h1216, 2'd0, 4'd1, 4'd8, 16'h0000, 2'd1, 3'd4, 1'b0},
    {16'h12B0, 2'd0, 4'd6, 4'd8, 16'h0000, 2'd1, 3'd3, 1'b0},
    {16'h1300, 2'd0, 4'd8, 4'd8, 16'h0000, 2'd0, 3'd3, 1'b0},
    {16'h1124, 2'd0, 4'd2, 4'd8, 16'h0000, 2'd0, 3'd3, 1'b0},
    {16'h1213, 2'd0, 4'd7, 4'd8, 16'h0001, 2'd0, 3'd2, 1'b0},
    {16'h10C4, 2'd0, 4'd8, 4'd8, 16'h0000, 2'd0, 3'd0, 1'b1},
    {16'h1380, 2'd0, 4'd8, 4'd8, 16'h0000, 2'd0, 3'd0, 1'b1},
    {16'h1301, 2'd0, 4'd8, 4'd8, 16'h0000, 2'd0, 3'd0, 1'b1},
    {16'h0000, 2'd3, 4'd8, 4'd8, 16'h0000, 2'd0, 3'd0, 1'b1},
    {16'h1400, 2'd3, 4'd8, 4'd8, 16'h0000, 2'd0, 3'd0, 1'b1},
    {16'h3FFF, 2'd1, 4'd8, 4'd8, 16'h0000, 2'd0, 3'd2, 1'b0},
    {16'h2005, 2'd1, 4'd8, 4'd8, 16'h0000, 2'd0, 3'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        out_valid, byte_op, is_reti, illegal;
  logic [1:0]  fmt, ext_words;
  logic [3:0]  opcode, src_reg, dst_reg, src_kind, dst_kind;
  logic [15:0] src_const, jump_disp;
  logic [2:0]  cycles;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  instr_decoder u_instr_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .out_valid(out_valid), .fmt(fmt), .opcode(opcode), .byte_op(byte_op),
    .src_reg(src_reg), .dst_reg(dst_reg), .src_kind(src_kind), .dst_kind(dst_kind),
    .src_const(src_const), .ext_words(ext_words), .cycles(cycles),
    .jump_disp(jump_disp), .is_reti(is_reti), .illegal(illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] w, input logic v);
    in_valid = v;
    instr    = w;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset out_valid", 32'(out_valid), 32'd0);
    check("R11 reset src_kind", 32'(src_kind), 32'd8);
    check("R11 reset fmt", 32'(fmt), 32'd3);
    check("R11 reset cycles", 32'(cycles), 32'd0);
    rst = 1'b0;
    step(16'h0000, 1'b0);

    // table walk: R1 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][47:32], 1'b1);
      check("R11 out_valid", 32'(out_valid), 32'd1);
      check("R1 fmt", 32'(fmt), 32'(VEC[i][31:30]));
      check("R3 src_kind", 32'(src_kind), 32'(VEC[i][29:26]));
      check("R3 dst_kind", 32'(dst_kind), 32'(VEC[i][25:22]));
      check("R6 src_const", 32'(src_const), 32'(VEC[i][21:6]));
      check("R7 ext_words", 32'(ext_words), 32'(VEC[i][5:4]));
      check("R8 cycles", 32'(cycles), 32'(VEC[i][3:1]));
      check("R10 illegal", 32'(illegal), 32'(VEC[i][0]));
    end

    // R2 field extraction
    step(16'h4445, 1'b1);
    check("R2 opcode", 32'(opcode), 32'h4);
    check("R2 byte_op", 32'(byte_op), 32'd1);
    check("R2 src_reg", 32'(src_reg), 32'd4);
    check("R2 dst_reg", 32'(dst_reg), 32'd5);
    step(16'hE72A, 1'b1);
    check("R2 opcode xor", 32'(opcode), 32'hE);
    check("R2 byte_op word", 32'(byte_op), 32'd0);
    check("R2 src_reg 7", 32'(src_reg), 32'd7);
    check("R2 dst_reg A", 32'(dst_reg), 32'hA);
    check("R3 indirect src", 32'(src_kind), 32'd2);
    step(16'h1049, 1'b1);
    check("R2 single opcode", 32'(opcode), 32'd0);
    check("R2 single byte", 32'(byte_op), 32'd1);
    check("R2 single reg", 32'(src_reg), 32'd9);

    // R9 branch displacement at the extremes
    step(16'h3FFF, 1'b1);
    check("R9 disp -1", 32'(jump_disp), 32'hFFFE);
    check("R9 cond 7", 32'(opcode), 32'd7);
    step(16'h2600, 1'b1);
    check("R9 disp min", 32'(jump_disp), 32'hFC00);
    check("R9 cond 1", 32'(opcode), 32'd1);
    step(16'h21FF, 1'b1);
    check("R9 disp max", 32'(jump_disp), 32'h03FE);
    check("R9 cond 0", 32'(opcode), 32'd0);

    // R10 return-from-interrupt
    step(16'h1300, 1'b1);
    check("R10 reti set", 32'(is_reti), 32'd1);
    step(16'h1301, 1'b1);
    check("R10 reti clear", 32'(is_reti), 32'd0);

    // R11 hold while idle
    step(16'h5495, 1'b1);
    step(16'h4405, 1'b0);
    check("R11 idle valid", 32'(out_valid), 32'd0);
    check("R11 idle hold cycles", 32'(cycles), 32'd6);
    check("R11 idle hold kind", 32'(dst_kind), 32'd1);
    step(16'h4405, 1'b1);
    check("R11 resume cycles", 32'(cycles), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule